// File: doc/BRIEF.md
# Multi-mode pixel lane serializer

This block turns parallel video pixels into serial bit streams for a set of LVDS-style data lanes. Every lane carries a seven-bit slice of the current pixel word per pixel clock period. Each link also has a forwarded clock lane that repeats a fixed seven-bit pattern once per period. The pixel words are captured on the pixel clock. The shifting runs on a bit clock that is phase-locked to the pixel clock at seven times its rate. The analog drivers and the PLL that makes the bit clock are outside the block.

There are two links, A and B, and each has four data lanes. Two mode inputs select single-pixel or dual-pixel operation and a colour depth of 24 or 18 bits per pixel. In single-pixel mode only link A runs. In dual-pixel mode link A carries the odd pixel and link B carries the even pixel, and both links repeat the sync and data-enable flags. In 18-bit mode the fourth lane of every active link is switched off, which saves power in the drivers. Every lane that is off reports its enable low, and a low enable means the pad is in tri-state.

Top module: `lvds_px_serializer`

## Requirements
- R1: Each data lane sends exactly seven bits per pixel period, one bit per bit clock, and the leftmost bit of its lane word goes first.
- R2: Each enabled clock lane repeats the seven-bit pattern 1100011 in every pixel period, leftmost bit first, and its first slot of a period is high. The link A clock lane stays enabled after reset.
- R3: The lane words are fixed, leftmost bit first, with colour bits taken from the pixel bus as R = bus[23:16], G = bus[15:8], B = bus[7:0]. Lane 0 is {R7..R2, G7}. Lane 1 is {G6..G2, B7, B6}. Lane 2 is {B5..B2, HS, VS, DE}. Lane 3 is {R1, R0, G1, G0, B1, B0, spare}.
- R4: When `dual_pix` = 0 (single-pixel), all four link B data lanes and the link B clock lane have their enable low and their data low.
- R5: When `dual_pix` = 1, link A carries `odd_rgb` with `spare_odd`, and link B carries `even_rgb` with `spare_even`, both through the R3 map.
- R6: In dual-pixel mode, HS, VS and DE appear in lane 2 of both link A and link B.
- R7: When `depth_18` = 1, lane 3 of each active link has its enable low and its data low. The inputs that map to lane 3 (the two low bits of each colour and the spare bit) have no effect on any output.
- R8: A spare input bit comes out unchanged in the last slot of lane 3 of its link.
- R9: A change of `dual_pix` or `depth_18` takes effect only at a pixel word boundary. Lane enables never change within a word.
- R10: All pixel inputs are captured on the rising edge of `pix_clk`. An input change that is reversed before the next rising edge has no effect on the serial output.
- R11: While `rst_n` is low, every data output and every enable output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock; input capture |
| bit_clk | input | 1 | Bit clock, seven times pix_clk and phase-locked to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_pix | input | 1 | 1 = dual-pixel (both links), 0 = single-pixel (link A only) |
| depth_18 | input | 1 | 1 = 18 bits per pixel (lane 3 off), 0 = 24 bits per pixel |
| odd_rgb | input | 24 | Odd (or only) pixel colour, {R,G,B} |
| even_rgb | input | 24 | Even pixel colour, {R,G,B}, used in dual-pixel mode |
| hsync | input | 1 | Horizontal sync flag |
| vsync | input | 1 | Vertical sync flag |
| de | input | 1 | Data-enable flag |
| spare_odd | input | 1 | General-purpose bit sent with link A |
| spare_even | input | 1 | General-purpose bit sent with link B |
| lane_a_dat | output | 4 | Serial data, link A lanes 0..3 |
| lane_a_en | output | 4 | Driver enable, link A lanes 0..3 |
| lane_b_dat | output | 4 | Serial data, link B lanes 0..3 |
| lane_b_en | output | 4 | Driver enable, link B lanes 0..3 |
| clk_a_dat | output | 1 | Link A clock-lane serial pattern |
| clk_a_en | output | 1 | Link A clock-lane enable |
| clk_b_dat | output | 1 | Link B clock-lane serial pattern |
| clk_b_en | output | 1 | Link B clock-lane enable |

## Verification
A mode change and a word load can happen in the same bit clock. The new mode is captured with a pixel edge partway through a word, and the next word load must pick it up without reaching the word that is already shifting. The bench provokes this by switching `dual_pix` and `depth_18` back and forth every few pixel periods. It uses the link A clock pattern to find word boundaries, and it counts every enable transition that falls anywhere other than the first slot of a word. A checker property requires, cycle by cycle, that the enables hold steady on every bit clock that is not a load.

// File: rtl/lvds_px_pkg.sv
package lvds_px_pkg;

   localparam int SLOTS   = 7;
   localparam int DLANES  = 4;
   localparam int COLOR_W = 8;
   localparam int PIX_W   = 3 * COLOR_W;
   localparam int LINK_W  = DLANES * SLOTS;

   typedef struct packed {
      logic [PIX_W-1:0] rgb;
      logic             hs;
      logic             vs;
      logic             de;
      logic             sp;
   } pix_t;

   typedef struct packed {
      logic dual;
      logic d18;
   } mode_t;

   // Lane i occupies bits [i*SLOTS +: SLOTS]; leftmost bit of a lane goes first.
   function automatic logic [LINK_W-1:0] pack_link(input pix_t p);
      logic [COLOR_W-1:0] r, g, b;
      r = p.rgb[3*COLOR_W-1:2*COLOR_W];
      g = p.rgb[2*COLOR_W-1:COLOR_W];
      b = p.rgb[COLOR_W-1:0];
      return {{r[1:0], g[1:0], b[1:0], p.sp},
              {b[5:2], p.hs, p.vs, p.de},
              {g[6:2], b[7:6]},
              {r[7:2], g[7]}};
   endfunction

endpackage

// File: rtl/lvds_px_capture.sv
module lvds_px_capture
   import lvds_px_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dual_pix,
   input  logic             depth_18,
   input  logic [PIX_W-1:0] odd_rgb,
   input  logic [PIX_W-1:0] even_rgb,
   input  logic             hsync,
   input  logic             vsync,
   input  logic             de,
   input  logic             spare_odd,
   input  logic             spare_even,
   output pix_t             pix_a,
   output pix_t             pix_b,
   output mode_t            mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_a  <= '0;
         pix_b  <= '0;
         mode_q <= '0;
      end else begin
         pix_a  <= '{rgb: odd_rgb,  hs: hsync, vs: vsync, de: de, sp: spare_odd};
         pix_b  <= '{rgb: even_rgb, hs: hsync, vs: vsync, de: de, sp: spare_even};
         mode_q <= '{dual: dual_pix, d18: depth_18};
      end
   end

endmodule

// File: rtl/lvds_px_phase.sv
module lvds_px_phase #(
   parameter int SLOTS = 7,
   localparam int PW   = $clog2(SLOTS)
) (
   input  logic clk,
   input  logic rst_n,
   output logic load
);

   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (cnt == PW'(SLOTS - 1))
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign load = (cnt == '0);

endmodule

// File: rtl/lvds_px_lanemap.sv
module lvds_px_lanemap
   import lvds_px_pkg::*;
#(
   parameter bit LINK_B = 1'b0
) (
   input  pix_t                          pix,
   input  mode_t                         mode,
   output logic [DLANES-1:0][SLOTS-1:0]  words,
   output logic [DLANES-1:0]             lane_on,
   output logic                          clk_on
);

   logic link_on;

   generate
      if (LINK_B) begin : g_second
         assign link_on = mode.dual;
      end else begin : g_first
         assign link_on = 1'b1;
      end
   endgenerate

   assign words  = pack_link(pix);
   assign clk_on = link_on;

   generate
      for (genvar i = 0; i < DLANES; i++) begin : g_lane
         if (i == DLANES - 1) begin : g_low_bits
            assign lane_on[i] = link_on & ~mode.d18;
         end else begin : g_core
            assign lane_on[i] = link_on;
         end
      end
   endgenerate

endmodule

// File: rtl/lvds_px_lane_ser.sv
module lvds_px_lane_ser #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         en_in,
   input  logic [W-1:0] word,
   output logic         sdo,
   output logic         sen
);

   logic [W-1:0] sr;
   logic         en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         en_q <= 1'b0;
      end else if (load) begin
         en_q <= en_in;
         sr   <= en_in ? word : '0;
      end else begin
         sr   <= {sr[W-2:0], 1'b0};
      end
   end

   assign sdo = sr[W-1];
   assign sen = en_q;

endmodule

// File: rtl/lvds_px_serializer.sv
module lvds_px_serializer
   import lvds_px_pkg::*;
#(
   parameter int             SLOTS_P  = SLOTS,
   parameter int             DLANES_P = DLANES,
   parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011
) (
   input  logic                 pix_clk,
   input  logic                 bit_clk,
   input  logic                 rst_n,
   input  logic                 dual_pix,
   input  logic                 depth_18,
   input  logic [PIX_W-1:0]     odd_rgb,
   input  logic [PIX_W-1:0]     even_rgb,
   input  logic                 hsync,
   input  logic                 vsync,
   input  logic                 de,
   input  logic                 spare_odd,
   input  logic                 spare_even,
   output logic [DLANES-1:0]    lane_a_dat,
   output logic [DLANES-1:0]    lane_a_en,
   output logic [DLANES-1:0]    lane_b_dat,
   output logic [DLANES-1:0]    lane_b_en,
   output logic                 clk_a_dat,
   output logic                 clk_a_en,
   output logic                 clk_b_dat,
   output logic                 clk_b_en
);

   localparam int NLINK = 2;

   generate
      if (SLOTS_P != SLOTS) begin : g_bad_slots
         $error("lane slot count must match the fixed lane map");
      end
      if (DLANES_P != DLANES) begin : g_bad_lanes
         $error("data lane count must match the fixed lane map");
      end
      if (CLK_PAT[SLOTS-1] != 1'b1 || CLK_PAT == '1) begin : g_bad_pat
         $error("clock pattern must start high and contain a low slot");
      end
   endgenerate

   pix_t  pix_a, pix_b;
   mode_t mode_q;
   logic  w_load;

   logic [DLANES-1:0] sdo  [NLINK];
   logic [DLANES-1:0] sen  [NLINK];
   logic              csdo [NLINK];
   logic              csen [NLINK];

   lvds_px_capture u_cap (
      .clk        (pix_clk),
      .rst_n      (rst_n),
      .dual_pix   (dual_pix),
      .depth_18   (depth_18),
      .odd_rgb    (odd_rgb),
      .even_rgb   (even_rgb),
      .hsync      (hsync),
      .vsync      (vsync),
      .de         (de),
      .spare_odd  (spare_odd),
      .spare_even (spare_even),
      .pix_a      (pix_a),
      .pix_b      (pix_b),
      .mode_q     (mode_q)
   );

   lvds_px_phase #(.SLOTS(SLOTS)) u_phase (
      .clk   (bit_clk),
      .rst_n (rst_n),
      .load  (w_load)
   );

   generate
      for (genvar L = 0; L < NLINK; L++) begin : g_link
         logic [DLANES-1:0][SLOTS-1:0] words;
         logic [DLANES-1:0]            lane_on;
         logic                         clk_on;

         lvds_px_lanemap #(.LINK_B(L == 1)) u_map (
            .pix     ((L == 0) ? pix_a : pix_b),
            .mode    (mode_q),
            .words   (words),
            .lane_on (lane_on),
            .clk_on  (clk_on)
         );

         for (genvar i = 0; i < DLANES; i++) begin : g_ser
            lvds_px_lane_ser #(.W(SLOTS)) u_ser (
               .clk   (bit_clk),
               .rst_n (rst_n),
               .load  (w_load),
               .en_in (lane_on[i]),
               .word  (words[i]),
               .sdo   (sdo[L][i]),
               .sen   (sen[L][i])
            );
         end

         lvds_px_lane_ser #(.W(SLOTS)) u_clk_ser (
            .clk   (bit_clk),
            .rst_n (rst_n),
            .load  (w_load),
            .en_in (clk_on),
            .word  (CLK_PAT),
            .sdo   (csdo[L]),
            .sen   (csen[L])
         );
      end
   endgenerate

   assign lane_a_dat = sdo[0];
   assign lane_a_en  = sen[0];
   assign lane_b_dat = sdo[1];
   assign lane_b_en  = sen[1];
   assign clk_a_dat  = csdo[0];
   assign clk_a_en   = csen[0];
   assign clk_b_dat  = csdo[1];
   assign clk_b_en   = csen[1];

endmodule

// File: rtl/lvds_px_serializer_chk.sv
module lvds_px_serializer_chk #(
   parameter int               SLOTS   = 7,
   parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011
) (
   input logic       bit_clk,
   input logic       rst_n,
   input logic       load,
   input logic [3:0] lane_a_dat,
   input logic [3:0] lane_a_en,
   input logic [3:0] lane_b_dat,
   input logic [3:0] lane_b_en,
   input logic       clk_a_dat,
   input logic       clk_a_en,
   input logic       clk_b_dat,
   input logic       clk_b_en
);

   AST_EN_WORD_ALIGNED: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !load |=> $stable({lane_a_en, lane_b_en, clk_a_en, clk_b_en})); // R9

   AST_OFF_LANE_LOW: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (((lane_a_dat & ~lane_a_en) | (lane_b_dat & ~lane_b_en)) == 4'b0)
      && !(clk_b_dat && !clk_b_en) && !(clk_a_dat && !clk_a_en)); // R7

   AST_LINK_B_GROUPED: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !clk_b_en |-> (lane_b_en == 4'b0)); // R4

   AST_LANE3_PAIRED: assert property (@(posedge bit_clk) disable iff (!rst_n)
      lane_b_en[3] |-> lane_a_en[3]); // R7

   AST_LOAD_SPACED: assert property (@(posedge bit_clk) disable iff (!rst_n)
      load |=> !load); // R1

   AST_CLK_FIRST_SLOT: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (load && clk_a_en) |=> (clk_a_dat == CLK_PAT[SLOTS-1])); // R2

   AST_CLK_A_HELD: assert property (@(posedge bit_clk) disable iff (!rst_n)
      clk_a_en |=> clk_a_en); // R2

endmodule

bind lvds_px_serializer lvds_px_serializer_chk #(
   .SLOTS   (SLOTS),
   .CLK_PAT (CLK_PAT)
) u_chk (
   .bit_clk    (bit_clk),
   .rst_n      (rst_n),
   .load       (w_load),
   .lane_a_dat (lane_a_dat),
   .lane_a_en  (lane_a_en),
   .lane_b_dat (lane_b_dat),
   .lane_b_en  (lane_b_en),
   .clk_a_dat  (clk_a_dat),
   .clk_a_en   (clk_a_en),
   .clk_b_dat  (clk_b_dat),
   .clk_b_en   (clk_b_en)
);

// File: tb/lvds_px_serializer_tb.sv
module lvds_px_serializer_tb;

   localparam logic [6:0] PAT = 7'b1100011;

   logic        pix_clk = 1'b0;
   logic        bit_clk = 1'b0;
   logic        rst_n   = 1'b0;
   logic        dual_pix = 1'b0, depth_18 = 1'b0;
   logic [23:0] odd_rgb = '0, even_rgb = '0;
   logic        hsync = 0, vsync = 0, de = 0, spare_odd = 0, spare_even = 0;
   logic [3:0]  lane_a_dat, lane_a_en, lane_b_dat, lane_b_en;
   logic        clk_a_dat, clk_a_en, clk_b_dat, clk_b_en;

   int nchk = 0, nfail = 0;
   int nframes = 0, mixed = 0, mism = 0;
   bit armed = 0, first_of_frame = 0;

   logic [6:0] cap_a [4] = '{default: '0};
   logic [6:0] cap_b [4] = '{default: '0};
   logic [6:0] cap_ca = '0, cap_cb = '0;
   logic [6:0] frm_a [4] = '{default: '0};
   logic [6:0] frm_b [4] = '{default: '0};
   logic [6:0] frm_cb = '0;
   logic [6:0] exp_a [4] = '{default: '0};
   logic [3:0] frm_en_a = '0, frm_en_b = '0;
   logic       frm_cb_en = 0;
   logic [9:0] prev_en = '0;

   lvds_px_serializer u_dut (
      .pix_clk(pix_clk), .bit_clk(bit_clk), .rst_n(rst_n),
      .dual_pix(dual_pix), .depth_18(depth_18),
      .odd_rgb(odd_rgb), .even_rgb(even_rgb),
      .hsync(hsync), .vsync(vsync), .de(de),
      .spare_odd(spare_odd), .spare_even(spare_even),
      .lane_a_dat(lane_a_dat), .lane_a_en(lane_a_en),
      .lane_b_dat(lane_b_dat), .lane_b_en(lane_b_en),
      .clk_a_dat(clk_a_dat), .clk_a_en(clk_a_en),
      .clk_b_dat(clk_b_dat), .clk_b_en(clk_b_en)
   );

   // 50 MHz bit clock; pixel clock at one seventh, edges offset from bit edges
   initial forever #10 bit_clk = ~bit_clk;
   initial begin
      #5;
      forever begin
         pix_clk = 1'b1; #70;
         pix_clk = 1'b0; #70;
      end
   end

   // Deserialize at the falling bit edge, framing on the link A clock pattern
   always @(negedge bit_clk) begin
      logic       bnd;
      logic [9:0] en_now;
      for (int ln = 0; ln < 4; ln++) begin
         cap_a[ln] = {cap_a[ln][5:0], lane_a_dat[ln]};
         cap_b[ln] = {cap_b[ln][5:0], lane_b_dat[ln]};
      end
      cap_ca = {cap_ca[5:0], clk_a_dat};
      cap_cb = {cap_cb[5:0], clk_b_dat};
      bnd = (cap_ca == PAT);
      if (bnd) begin
         frm_a = cap_a;
         frm_b = cap_b;
         frm_cb = cap_cb;
         frm_en_a = lane_a_en;
         frm_en_b = lane_b_en;
         frm_cb_en = clk_b_en;
         nframes++;
         if (armed)
            for (int ln = 0; ln < 4; ln++)
               if (frm_a[ln] !== exp_a[ln]) mism++;
      end
      en_now = {lane_a_en, lane_b_en, clk_a_en, clk_b_en};
      if (nframes > 0 && !first_of_frame && en_now !== prev_en) mixed++;
      prev_en = en_now;
      first_of_frame = bnd;
   end

   function automatic logic [6:0] exp_lane(input int ln, input logic [23:0] c,
                                           input logic h, v, d, s);
      logic [7:0] r, g, b;
      r = c[23:16]; g = c[15:8]; b = c[7:0];
      case (ln)
         0: return {r[7], r[6], r[5], r[4], r[3], r[2], g[7]};
         1: return {g[6], g[5], g[4], g[3], g[2], b[7], b[6]};
         2: return {b[5], b[4], b[3], b[2], h, v, d};
         default: return {r[1], r[0], g[1], g[0], b[1], b[0], s};
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [6:0] act, input logic [6:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic wait_frames(input int n);
      int s = nframes;
      while (nframes < s + n) @(posedge bit_clk);
   endtask

   task automatic apply(input logic dp, d18, input logic [23:0] o, e,
                        input logic h, v, d, so, se);
      @(negedge pix_clk);
      dual_pix = dp; depth_18 = d18; odd_rgb = o; even_rgb = e;
      hsync = h; vsync = v; de = d; spare_odd = so; spare_even = se;
   endtask

   task automatic t_reset();
      #100;
      chk("R11", "data in reset", 7'({lane_a_dat, lane_b_dat, clk_a_dat, clk_b_dat} != 0), 7'd0);
      chk("R11", "enables in reset", 7'({lane_a_en, lane_b_en, clk_a_en, clk_b_en} != 0), 7'd0);
      #203;
      rst_n = 1'b1;
   endtask

   task automatic t_single24(input logic [23:0] c, input logic h, v, d, s);
      apply(1'b0, 1'b0, c, ~c, h, v, d, s, ~s);
      wait_frames(4);
      for (int ln = 0; ln < 4; ln++)
         chk("R1 R3", $sformatf("single24 lane A%0d", ln), frm_a[ln], exp_lane(ln, c, h, v, d, s));
      chk("R2", "link A clock pattern", cap_ca, PAT);
      chk("R3", "single24 A enables", 7'(frm_en_a), 7'hF);
      chk("R4", "single B enables", 7'({frm_en_b, frm_cb_en}), 7'd0);
      chk("R4", "single B lane data", frm_b[0] | frm_b[1] | frm_b[2] | frm_b[3] | frm_cb, 7'd0);
      chk("R8", "spare on A", 7'(frm_a[3][0]), 7'(s));
   endtask

   task automatic t_dual24(input logic [23:0] o, e, input logic h, v, d, so, se);
      apply(1'b1, 1'b0, o, e, h, v, d, so, se);
      wait_frames(4);
      for (int ln = 0; ln < 4; ln++) begin
         chk("R5", $sformatf("dual odd lane A%0d", ln), frm_a[ln], exp_lane(ln, o, h, v, d, so));
         chk("R5", $sformatf("dual even lane B%0d", ln), frm_b[ln], exp_lane(ln, e, h, v, d, se));
      end
      chk("R2", "link B clock pattern", frm_cb, PAT);
      chk("R5", "dual enables", 7'({frm_en_a, frm_en_b, frm_cb_en} == 9'h1FF), 7'd1);
      chk("R6", "sync flags on A", 7'(frm_a[2][2:0]), 7'({h, v, d}));
      chk("R6", "sync flags on B", 7'(frm_b[2][2:0]), 7'({h, v, d}));
      chk("R8", "spare on B", 7'(frm_b[3][0]), 7'(se));
   endtask

   task automatic t_depth18(input logic dp, input logic [23:0] o, e);
      for (int k = 0; k < 2; k++) begin
         logic [23:0] oo = k ? (o | 24'h030303) : (o & ~24'h030303);
         logic [23:0] ee = k ? (e & ~24'h030303) : (e | 24'h030303);
         apply(dp, 1'b1, oo, ee, 1'b1, 1'b0, 1'b1, k[0], ~k[0]);
         wait_frames(4);
         chk("R7", "A lane 3 enable", 7'(frm_en_a[3]), 7'd0);
         chk("R7", "A lane 3 data", frm_a[3], 7'd0);
         for (int ln = 0; ln < 3; ln++)
            chk("R7", $sformatf("18bpp lane A%0d", ln), frm_a[ln], exp_lane(ln, o, 1, 0, 1, 0));
         if (dp) begin
            chk("R7", "B lane 3 enable", 7'(frm_en_b[3]), 7'd0);
            chk("R7", "B lane 3 data", frm_b[3], 7'd0);
            for (int ln = 0; ln < 3; ln++)
               chk("R7", $sformatf("18bpp lane B%0d", ln), frm_b[ln], exp_lane(ln, e, 1, 0, 1, 0));
            chk("R7", "B core enables", 7'(frm_en_b[2:0]), 7'h7);
         end else begin
            chk("R4", "single18 B off", 7'({frm_en_b, frm_cb_en}), 7'd0);
         end
      end
   endtask

   task automatic t_mode_switch();
      mixed = 0;
      for (int k = 0; k < 8; k++) begin
         apply(k[0], k[1], 24'hC3A51E, 24'h3C5AE1, 1, 1, 0, 1, 0);
         wait_frames(2);
      end
      chk("R9", "enable change inside a word", 7'(mixed), 7'd0);
      wait_frames(2);
      chk("R9", "final mode enables", 7'({frm_en_a, frm_en_b}), 7'({4'b0111, 4'b0111}));
   endtask

   task automatic t_glitch(input logic [23:0] c);
      apply(1'b0, 1'b0, c, 24'h0, 0, 1, 1, 1, 0);
      for (int ln = 0; ln < 4; ln++) exp_a[ln] = exp_lane(ln, c, 0, 1, 1, 1);
      wait_frames(4);
      mism = 0;
      armed = 1;
      @(posedge pix_clk);
      #20 odd_rgb = ~c; hsync = 1;
      #40 odd_rgb = c;  hsync = 0;
      wait_frames(5);
      armed = 0;
      chk("R10", "frames disturbed by glitch", 7'(mism), 7'd0);
   endtask

   initial begin
      t_reset();
      t_single24(24'hA5C3F0, 1, 0, 1, 1);
      t_single24(24'h5A3C0F, 0, 1, 0, 0);
      t_single24(24'hFFFFFF, 1, 1, 1, 1);
      t_dual24(24'h123456, 24'hFEDCBA, 1, 0, 1, 0, 1);
      t_dual24(24'h81C37E, 24'h0F0F0F, 0, 1, 1, 1, 0);
      t_depth18(1'b0, 24'hB4D2E8, 24'h0);
      t_depth18(1'b1, 24'h6C9A3F, 24'hE17B54);
      t_mode_switch();
      t_glitch(24'h96E14B);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #2000000;
      nchk++;
      nfail++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule